// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block governs every change of privilege for a small in-order processor. It watches the instruction that is retiring and the external interrupt line. It decides, on each clock, whether the core stays where it is, enters supervisor mode, or returns to the interrupted context. Each entry happens on a single clock edge. In that edge the block stores the user PC, the user stack pointer and the old privilege bit in a save bank, loads the kernel stack pointer, raises privilege, and redirects fetch to a handler vector.

A system call lands on its own vector. Its saved PC is the following instruction. An exception, an interrupt, or a refused privileged operation lands on a shared trap vector, with the faulting PC and a cause code recorded. A return-from-trap puts back the saved privilege, SP and PC. The handler builds a return frame and controls interrupt acceptance through a small kernel-only control write port.

The controller is a three-state machine:
- ST_BOOT: the single cycle after reset, while fetch is redirected to the boot address.
- ST_KERNEL: privilege 1.
- ST_USER: privilege 0.

Its transitions are:
- boot_done: ST_BOOT to ST_KERNEL.
- trap_entry: any state except ST_BOOT to ST_KERNEL.
- return_user: ST_KERNEL to ST_USER, when the saved privilege is 0.
- return_kernel: ST_KERNEL to ST_KERNEL, when the saved privilege is 1.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While reset is held, and in the ST_BOOT cycle that follows it, the block shows the following: priv_mode 1, redirect_valid 1 with redirect_pc equal to BOOT_ADDR, sp_load 0, irq_enable 0, saved_priv 1, and saved_pc, saved_sp and cause_code all 0.
- R2: A system call taken at cur_pc produces, one cycle later, the following: redirect_valid and sp_load both pulse, redirect_pc is SYSCALL_VEC, sp_value is KSTACK_TOP, saved_pc is cur_pc+INSTR_BYTES (modulo 2^AW), saved_sp is cur_sp, saved_priv is the old privilege, and priv_mode is 1. cause_code is left unchanged.
- R3: An exception (ev_exc) redirects to TRAP_VEC and loads KSTACK_TOP. It saves cur_pc itself as the return PC, and cause_code becomes exc_code. An exception outranks a system call, a privileged operation, a return and a control write in the same cycle.
- R4: When irq_line is high and irq_enable is 1, an interrupt is taken in either privilege mode. It redirects to TRAP_VEC, saves cur_pc, and sets cause_code to IRQ_CAUSE. It has the highest priority of all events.
- R5: When a system call and an accepted interrupt fall in the same cycle, the interrupt is taken. saved_pc is then cur_pc, not cur_pc+INSTR_BYTES, so the system call runs again after the return.
- R6: In user mode, ev_priv_op, ev_return and ctl_wr are refused. Each one raises a trap to TRAP_VEC with cause_code PRIV_CAUSE, and it neither restores state nor writes any control field.
- R7: A return (ev_return) in kernel mode pulses redirect_valid and sp_load together. It sets redirect_pc to saved_pc, sp_value to saved_sp, and priv_mode to saved_priv.
- R8: Every trap entry clears irq_enable. While irq_enable is 0, irq_line has no effect. A kernel control write with ctl_sel 0 sets irq_enable to ctl_data bit 0.
- R9: After the boot cycle, redirect_valid and sp_load are always equal. An entry never shows a redirect without the stack switch and the saved state of the same edge.
- R10: Events presented during the ST_BOOT cycle are ignored. The block moves to ST_KERNEL with no redirect and no change to the saved state.
- R11: In kernel mode, ev_priv_op is allowed. It causes no trap, no redirect and no change of state.
- R12: In kernel mode, control writes fill the return frame as follows: ctl_sel 1 writes saved_priv from ctl_data bit 0, ctl_sel 2 writes saved_pc, and ctl_sel 3 writes saved_sp. Only the selected field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | AW | PC of the retiring instruction |
| cur_sp | input | AW | Current stack pointer |
| ev_syscall | input | 1 | Retiring instruction is a system call |
| ev_exc | input | 1 | Retiring instruction raised an exception |
| exc_code | input | CW | Cause code that goes with ev_exc |
| ev_priv_op | input | 1 | Retiring instruction is a privileged operation |
| ev_return | input | 1 | Retiring instruction is a return-from-trap |
| ctl_wr | input | 1 | Control write from the retiring instruction |
| ctl_sel | input | 2 | Control field: 0 irq enable, 1 saved priv, 2 saved PC, 3 saved SP |
| ctl_data | input | AW | Control write data |
| irq_line | input | 1 | External interrupt request, level |
| priv_mode | output | 1 | Current privilege: 1 kernel, 0 user |
| irq_enable | output | 1 | Interrupt acceptance bit |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | AW | Redirect target |
| sp_load | output | 1 | Stack pointer load pulse |
| sp_value | output | AW | Stack pointer value to load |
| saved_pc | output | AW | Saved return PC |
| saved_sp | output | AW | Saved stack pointer |
| saved_priv | output | 1 | Saved privilege bit |
| cause_code | output | CW | Last recorded trap cause |

## Verification
The bench builds the block with AW set to 16 and with short, distinct vectors. A system call at PC 16'hFFFC is then enough to reach the point where the saved return address wraps to zero. CW stays at 4, so the exception, interrupt and refusal cause codes can all be told apart on one port. A behavioural model walks the same priority rules on every clock. Runs of back-to-back entries and returns, collisions in the same cycle, traps nested in kernel mode, and interrupts held off while irq_enable is 0 are all compared on every cycle.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_KERNEL = 2'd1,
        ST_USER   = 2'd2
    } ctrl_state_e;

    typedef enum logic [2:0] {
        EV_NONE    = 3'd0,
        EV_IRQ     = 3'd1,
        EV_EXC     = 3'd2,
        EV_PRIV    = 3'd3,
        EV_SYSCALL = 3'd4,
        EV_RETURN  = 3'd5,
        EV_CTLWR   = 3'd6
    } ev_kind_e;

    typedef enum logic [1:0] {
        CF_IRQEN = 2'd0,
        CF_SPRIV = 2'd1,
        CF_SPC   = 2'd2,
        CF_SSP   = 2'd3
    } ctl_field_e;

    function automatic logic is_entry(ev_kind_e k);
        return (k == EV_IRQ) || (k == EV_EXC) || (k == EV_PRIV) || (k == EV_SYSCALL);
    endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
(
    input  logic     active,
    input  logic     priv,
    input  logic     irq_take,
    input  logic     ev_exc,
    input  logic     ev_priv_op,
    input  logic     ev_return,
    input  logic     ev_syscall,
    input  logic     ctl_wr,
    output ev_kind_e kind
);

    logic refused;

    assign refused = !priv && (ev_priv_op || ev_return || ctl_wr);

    always_comb begin
        kind = EV_NONE;
        if (!active) begin
            kind = EV_NONE;
        end else if (irq_take) begin
            kind = EV_IRQ;
        end else if (ev_exc) begin
            kind = EV_EXC;
        end else if (refused) begin
            kind = EV_PRIV;
        end else if (ev_syscall) begin
            kind = EV_SYSCALL;
        end else if (ev_return) begin
            kind = EV_RETURN;
        end else if (ctl_wr) begin
            kind = EV_CTLWR;
        end
    end

endmodule

// File: rtl/trap_save_bank.sv
module trap_save_bank
    import trap_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_en,
    input  logic [AW-1:0] pc_d,
    input  logic [AW-1:0] sp_d,
    input  logic          priv_d,
    input  logic          cause_en,
    input  logic [CW-1:0] cause_d,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] pc_q,
    output logic [AW-1:0] sp_q,
    output logic          priv_q,
    output logic [CW-1:0] cause_q
);

    ctl_field_e field;

    assign field = ctl_field_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            sp_q    <= '0;
            priv_q  <= 1'b1;
            cause_q <= '0;
        end else begin
            if (save_en) begin
                pc_q   <= pc_d;
                sp_q   <= sp_d;
                priv_q <= priv_d;
            end else if (wr_en) begin
                unique case (field)
                    CF_SPRIV: priv_q <= wr_data[0];
                    CF_SPC:   pc_q   <= wr_data;
                    CF_SSP:   sp_q   <= wr_data;
                    default:  ;
                endcase
            end
            if (cause_en) begin
                cause_q <= cause_d;
            end
        end
    end

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int unsigned   AW          = 32,
    parameter int unsigned   CW          = 4,
    parameter int unsigned   INSTR_BYTES = 4,
    parameter logic [AW-1:0] BOOT_ADDR   = 32'h0000_0100,
    parameter logic [AW-1:0] SYSCALL_VEC = 32'h0000_0200,
    parameter logic [AW-1:0] TRAP_VEC    = 32'h0000_0300,
    parameter logic [AW-1:0] KSTACK_TOP  = 32'h0000_F000,
    parameter logic [CW-1:0] IRQ_CAUSE   = 4'hF,
    parameter logic [CW-1:0] PRIV_CAUSE  = 4'hE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] cur_sp,
    input  logic          ev_syscall,
    input  logic          ev_exc,
    input  logic [CW-1:0] exc_code,
    input  logic          ev_priv_op,
    input  logic          ev_return,
    input  logic          ctl_wr,
    input  logic [1:0]    ctl_sel,
    input  logic [AW-1:0] ctl_data,
    input  logic          irq_line,
    output logic          priv_mode,
    output logic          irq_enable,
    output logic          redirect_valid,
    output logic [AW-1:0] redirect_pc,
    output logic          sp_load,
    output logic [AW-1:0] sp_value,
    output logic [AW-1:0] saved_pc,
    output logic [AW-1:0] saved_sp,
    output logic          saved_priv,
    output logic [CW-1:0] cause_code
);

    localparam logic [AW-1:0] PC_STEP = AW'(INSTR_BYTES);

    ctrl_state_e   state, state_nx;
    ev_kind_e      kind;
    logic          irq_en_q;
    logic          irq_take;
    logic          entry;
    logic          cause_en;
    logic [AW-1:0] save_pc;
    logic [CW-1:0] cause_d;

    assign priv_mode  = (state != ST_USER);
    assign irq_enable = irq_en_q;
    assign irq_take   = irq_line && irq_en_q;
    assign entry      = is_entry(kind);
    assign cause_en   = (kind == EV_IRQ) || (kind == EV_EXC) || (kind == EV_PRIV);
    assign save_pc    = (kind == EV_SYSCALL) ? cur_pc + PC_STEP : cur_pc;

    always_comb begin
        unique case (kind)
            EV_IRQ:  cause_d = IRQ_CAUSE;
            EV_PRIV: cause_d = PRIV_CAUSE;
            default: cause_d = exc_code;
        endcase
    end

    trap_arbiter u_arb (
        .active     (state != ST_BOOT),
        .priv       (priv_mode),
        .irq_take   (irq_take),
        .ev_exc     (ev_exc),
        .ev_priv_op (ev_priv_op),
        .ev_return  (ev_return),
        .ev_syscall (ev_syscall),
        .ctl_wr     (ctl_wr),
        .kind       (kind)
    );

    trap_save_bank #(.AW(AW), .CW(CW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .save_en  (entry),
        .pc_d     (save_pc),
        .sp_d     (cur_sp),
        .priv_d   (priv_mode),
        .cause_en (cause_en),
        .cause_d  (cause_d),
        .wr_en    (kind == EV_CTLWR),
        .wr_sel   (ctl_sel),
        .wr_data  (ctl_data),
        .pc_q     (saved_pc),
        .sp_q     (saved_sp),
        .priv_q   (saved_priv),
        .cause_q  (cause_code)
    );

    // Next-state logic: boot_done, trap_entry, return_user, return_kernel
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BOOT: state_nx = ST_KERNEL;
            ST_KERNEL, ST_USER: begin
                if (entry) begin
                    state_nx = ST_KERNEL;
                end else if (kind == EV_RETURN) begin
                    state_nx = saved_priv ? ST_KERNEL : ST_USER;
                end
            end
            default: state_nx = ST_KERNEL;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_BOOT;
        end else begin
            state <= state_nx;
        end
    end

    // Registered outputs: redirect, stack switch, interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b1;
            redirect_pc    <= BOOT_ADDR;
            sp_load        <= 1'b0;
            sp_value       <= '0;
            irq_en_q       <= 1'b0;
        end else begin
            redirect_valid <= 1'b0;
            sp_load        <= 1'b0;
            unique case (kind)
                EV_IRQ, EV_EXC, EV_PRIV: begin
                    redirect_valid <= 1'b1;
                    redirect_pc    <= TRAP_VEC;
                    sp_load        <= 1'b1;
                    sp_value       <= KSTACK_TOP;
                    irq_en_q       <= 1'b0;
                end
                EV_SYSCALL: begin
                    redirect_valid <= 1'b1;
                    redirect_pc    <= SYSCALL_VEC;
                    sp_load        <= 1'b1;
                    sp_value       <= KSTACK_TOP;
                    irq_en_q       <= 1'b0;
                end
                EV_RETURN: begin
                    redirect_valid <= 1'b1;
                    redirect_pc    <= saved_pc;
                    sp_load        <= 1'b1;
                    sp_value       <= saved_sp;
                end
                EV_CTLWR: begin
                    if (ctl_field_e'(ctl_sel) == CF_IRQEN) begin
                        irq_en_q <= ctl_data[0];
                    end
                end
                default: ;
            endcase
        end
    end

    // Assertions
    p_boot_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BOOT) |-> (priv_mode && redirect_valid &&
                                redirect_pc == BOOT_ADDR && !irq_en_q && !sp_load));

    p_syscall_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == EV_SYSCALL) |=> (redirect_valid && redirect_pc == SYSCALL_VEC &&
            sp_value == KSTACK_TOP && priv_mode &&
            saved_pc == $past(cur_pc) + PC_STEP && saved_sp == $past(cur_sp)));

    p_exc_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == EV_EXC) |=> (redirect_pc == TRAP_VEC && cause_code == $past(exc_code) &&
                              saved_pc == $past(cur_pc) && priv_mode));

    p_irq_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_BOOT && irq_line && irq_en_q) |=>
            (redirect_valid && redirect_pc == TRAP_VEC && cause_code == IRQ_CAUSE && !irq_en_q));

    p_user_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_USER && (ev_priv_op || ev_return || ctl_wr) && !(irq_line && irq_en_q) && !ev_exc)
            |=> (priv_mode && cause_code == PRIV_CAUSE && !saved_priv));

    p_return_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == EV_RETURN) |=> (priv_mode == $past(saved_priv) && redirect_pc == $past(saved_pc) &&
                                 sp_value == $past(saved_sp) && sp_load));

    p_atomic_switch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_BOOT) |-> (sp_load == redirect_valid));

    p_boot_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BOOT) |=> (!redirect_valid && priv_mode && $stable(saved_pc)));

endmodule

// File: tb/test_trap_entry_ctrl.sv
module test_trap_entry_ctrl;

    localparam int unsigned   AW    = 16;
    localparam int unsigned   CW    = 4;
    localparam logic [15:0]   BOOT  = 16'h0040;
    localparam logic [15:0]   SVEC  = 16'h0080;
    localparam logic [15:0]   TVEC  = 16'h00C0;
    localparam logic [15:0]   KSTK  = 16'hE000;
    localparam logic [3:0]    CIRQ  = 4'hF;
    localparam logic [3:0]    CPRIV = 4'hE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] cur_pc = '0, cur_sp = '0, ctl_data = '0;
    logic ev_syscall = 0, ev_exc = 0, ev_priv_op = 0, ev_return = 0, ctl_wr = 0, irq_line = 0;
    logic [3:0] exc_code = '0;
    logic [1:0] ctl_sel = '0;

    logic priv_mode, irq_enable, redirect_valid, sp_load, saved_priv;
    logic [15:0] redirect_pc, sp_value, saved_pc, saved_sp;
    logic [3:0] cause_code;

    always #10 clk = ~clk;

    trap_entry_ctrl #(
        .AW(AW), .CW(CW), .INSTR_BYTES(4), .BOOT_ADDR(BOOT), .SYSCALL_VEC(SVEC),
        .TRAP_VEC(TVEC), .KSTACK_TOP(KSTK), .IRQ_CAUSE(CIRQ), .PRIV_CAUSE(CPRIV)
    ) i_trap_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .cur_sp(cur_sp),
        .ev_syscall(ev_syscall), .ev_exc(ev_exc), .exc_code(exc_code),
        .ev_priv_op(ev_priv_op), .ev_return(ev_return), .ctl_wr(ctl_wr),
        .ctl_sel(ctl_sel), .ctl_data(ctl_data), .irq_line(irq_line),
        .priv_mode(priv_mode), .irq_enable(irq_enable), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .sp_load(sp_load), .sp_value(sp_value),
        .saved_pc(saved_pc), .saved_sp(saved_sp), .saved_priv(saved_priv),
        .cause_code(cause_code)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit done = 0;

    // Behavioural reference model
    bit m_boot, m_priv, m_ien, m_rv, m_sl, m_spriv;
    logic [15:0] m_rpc, m_spv, m_spc, m_ssp;
    logic [3:0] m_cause;

    task automatic m_enter(input logic [15:0] vec, input logic [15:0] ret_pc,
                           input bit rec, input logic [3:0] c);
        m_spc = ret_pc; m_ssp = cur_sp; m_spriv = m_priv;
        m_priv = 1; m_ien = 0; m_rv = 1; m_rpc = vec; m_sl = 1; m_spv = KSTK;
        if (rec) m_cause = c;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_boot = 1; m_priv = 1; m_ien = 0; m_rv = 1; m_rpc = BOOT; m_sl = 0; m_spv = 0;
            m_spc = 0; m_ssp = 0; m_spriv = 1; m_cause = 0;
        end else begin
            m_rv = 0; m_sl = 0;
            if (m_boot) m_boot = 0;
            else if (irq_line && m_ien) m_enter(TVEC, cur_pc, 1, CIRQ);
            else if (ev_exc) m_enter(TVEC, cur_pc, 1, exc_code);
            else if (!m_priv && (ev_priv_op || ev_return || ctl_wr)) m_enter(TVEC, cur_pc, 1, CPRIV);
            else if (ev_syscall) m_enter(SVEC, cur_pc + 16'd4, 0, 4'h0);
            else if (ev_return) begin
                m_rv = 1; m_rpc = m_spc; m_sl = 1; m_spv = m_ssp; m_priv = m_spriv;
            end else if (ctl_wr) begin
                case (ctl_sel)
                    2'd0: m_ien = ctl_data[0];
                    2'd1: m_spriv = ctl_data[0];
                    2'd2: m_spc = ctl_data;
                    default: m_ssp = ctl_data;
                endcase
            end
        end
    end

    task automatic cmp(input string nm, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            cmp("priv_mode", priv_mode, m_priv);
            cmp("irq_enable", irq_enable, m_ien);
            cmp("redirect_valid", redirect_valid, m_rv);
            cmp("redirect_pc", redirect_pc, m_rpc);
            cmp("sp_load", sp_load, m_sl);
            cmp("sp_value", sp_value, m_spv);
            cmp("saved_pc", saved_pc, m_spc);
            cmp("saved_sp", saved_sp, m_ssp);
            cmp("saved_priv", saved_priv, m_spriv);
            cmp("cause_code", cause_code, m_cause);
        end
    end

    task automatic clear_ev();
        ev_syscall = 0; ev_exc = 0; ev_priv_op = 0; ev_return = 0; ctl_wr = 0; irq_line = 0;
    endtask

    task automatic tick(input string req);
        cur_req = req;
        @(negedge clk);
        clear_ev();
    endtask

    task automatic wr_ctl(input string req, input logic [1:0] sel, input logic [15:0] d);
        ctl_wr = 1; ctl_sel = sel; ctl_data = d; tick(req);
    endtask

    task automatic go_user(input string req, input logic [15:0] pc, input logic [15:0] sp,
                           input bit ien);
        wr_ctl(req, 2'd2, pc);
        wr_ctl(req, 2'd3, sp);
        wr_ctl(req, 2'd1, 16'd0);
        wr_ctl(req, 2'd0, {15'd0, ien});
        ev_return = 1; tick(req);
        tick(req);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset and boot cycle values compared on this negedge
        cur_req = "R1";
        // R10: syscall presented during the boot cycle is ignored
        cur_pc = 16'h0040; cur_sp = 16'h1111; ev_syscall = 1; tick("R10");
        tick("R10");
        // R11: privileged op in kernel is allowed
        ev_priv_op = 1; tick("R11");
        // R8: irq ignored while irq_enable is 0
        irq_line = 1; tick("R8");
        irq_line = 1; tick("R8");
        // R12: return frame fields written one at a time
        wr_ctl("R12", 2'd2, 16'h1000);
        wr_ctl("R12", 2'd3, 16'h8000);
        wr_ctl("R12", 2'd1, 16'h0000);
        // R7: return to user
        ev_return = 1; tick("R7");
        tick("R7");
        // R2: syscall from user
        cur_pc = 16'h1010; cur_sp = 16'h7FF0; ev_syscall = 1; tick("R2");
        tick("R2");
        // R8: kernel enables interrupts; R7 return
        wr_ctl("R8", 2'd0, 16'h0001);
        ev_return = 1; tick("R7");
        tick("R7");
        // R3: exception in user, also clears irq_enable (R8)
        cur_pc = 16'h1020; cur_sp = 16'h7FE0; ev_exc = 1; exc_code = 4'h5; tick("R3");
        tick("R3");
        // R5: irq and syscall in the same cycle
        go_user("R5", 16'h1030, 16'h7FD0, 1);
        cur_pc = 16'h1030; ev_syscall = 1; irq_line = 1; tick("R5");
        tick("R5");
        // R4: irq in kernel with irq_enable set
        wr_ctl("R4", 2'd0, 16'h0001);
        cur_pc = 16'h0088; cur_sp = 16'hDFF0; irq_line = 1; tick("R4");
        tick("R4");
        // R8: irq in user with irq_enable 0
        go_user("R8", 16'h1040, 16'h7FC0, 0);
        irq_line = 1; tick("R8");
        // R6: privileged op, return and control write refused in user
        cur_pc = 16'h1044; ev_priv_op = 1; tick("R6");
        go_user("R6", 16'h1048, 16'h7FB0, 0);
        ev_return = 1; tick("R6");
        go_user("R6", 16'h104C, 16'h7FA0, 0);
        ctl_wr = 1; ctl_sel = 2'd0; ctl_data = 16'h0001; tick("R6");
        tick("R6");
        // R3: exception outranks syscall in the same cycle
        go_user("R3", 16'h1050, 16'h7F90, 0);
        cur_pc = 16'h1050; ev_exc = 1; exc_code = 4'h3; ev_syscall = 1; tick("R3");
        // R2: saved return address wraps at the top of the address space
        go_user("R2", 16'hFFFC, 16'h7F80, 0);
        cur_pc = 16'hFFFC; ev_syscall = 1; tick("R2");
        tick("R2");
        // R9: nested exception in kernel, return stays in kernel
        cur_pc = 16'h0084; cur_sp = 16'hDFE0; ev_exc = 1; exc_code = 4'h7; tick("R9");
        ev_return = 1; tick("R9");
        tick("R9");
        repeat (3) tick("R9");
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

endmodule